// File: doc/BRIEF.md
# Local Bus Access Timeout Monitor

This block watches every transfer on a local bus and answers a transfer that nobody claims. A transfer-start strobe opens a cycle and starts a timer. The cycle closes normally when the addressed slave returns a transfer acknowledge or a transfer error acknowledge. If neither response arrives before the selected limit runs out, the monitor sends a one-clock transfer-error pulse back to the bus master. That pulse lets the master abort the access instead of hanging on it.

The limit comes from a 2-bit select code. Three codes give limits of 8, 64 and 256 microseconds, and the fourth code switches the timer off. A separate enable input must be high for the monitor to act. A prescaler inside the block turns the system clock into a 1 µs tick. The clock frequency in MHz is a parameter. The prescaler restarts on every start strobe, so each limit is an exact number of clocks.

Top module: `lbus_tmo_monitor`

## Requirements
- R1: A start strobe sampled on a clock edge begins timing. With no response, `bus_err` goes high right after the edge that falls CLK_MHZ × limit clocks later.
- R2: Select code 0 gives a limit of 8 µs.
- R3: Select code 1 gives a limit of 64 µs.
- R4: Select code 2 gives a limit of 256 µs.
- R5: Select code 3 disables the timer, so `bus_err` is never asserted.
- R6: While `mon_enable` is 0, `bus_err` is never asserted, whatever the select code.
- R7: A transfer acknowledge sampled before expiry ends the cycle and no error follows.
- R8: A transfer error acknowledge sampled before expiry ends the cycle and no error follows.
- R9: A start strobe during a cycle that is still open restarts the count from zero.
- R10: `bus_err` lasts one clock. Afterwards the monitor is idle and raises no further error until a new start strobe.
- R11: An acknowledge sampled on the same edge as expiry wins, and no error is issued.
- R12: After reset `bus_err` is low and the monitor is idle. The select code in effect is registered and resets to code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_MHZ MHz |
| rst_n | input | 1 | Synchronous active-low reset |
| xfer_start | input | 1 | Transfer-start strobe, one clock per transfer |
| xfer_ack | input | 1 | Slave transfer acknowledge |
| xfer_err_ack | input | 1 | Slave transfer error acknowledge |
| tmo_sel | input | 2 | Timeout select: 0 = 8 µs, 1 = 64 µs, 2 = 256 µs, 3 = off |
| mon_enable | input | 1 | Enable qualifier. When 0, no error is ever produced |
| bus_err | output | 1 | Transfer-error pulse to the bus master, one clock wide |

## Verification
The bench measures the exact clock count from the start strobe to the error for each of the three limits. A prescaler that runs free, or that is off by one, shows up as a count that is a few clocks wrong or as a wrong limit.

It also covers these cases:
- An acknowledge placed on the very edge where the count expires, where a design that checks expiry before responses would still send an error.
- A second start strobe in the middle of a cycle, where a design that ignores it would time out early, counted from the first strobe.
- The disabled code and the enable input held low across a long wait, where a wrong decode of the select code would produce an error.
- The idle time after an error, where a design that stays armed would pulse again.

// File: rtl/lbto_pkg.sv
// Package: shared select-code type and limit helpers for the timeout monitor.
// Assumes limits are given in whole microseconds.
package lbto_pkg;

    typedef enum logic [1:0] {
        SEL_SHORT = 2'd0,
        SEL_MID   = 2'd1,
        SEL_LONG  = 2'd2,
        SEL_OFF   = 2'd3
    } tmo_sel_e;

    // Largest of three limits, used to size the microsecond counter.
    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/lbto_tick_gen.sv
// Module: lbto_tick_gen
// Divides the system clock into a 1 us tick. The divider clears on restart and
// whenever run is low, so the first tick comes exactly CLK_MHZ clocks after the restart.
// Assumes CLK_MHZ >= 1.
module lbto_tick_gen #(
    parameter int unsigned CLK_MHZ = 125
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
    localparam logic [PW-1:0] LAST = PW'(CLK_MHZ - 1);

    logic [PW-1:0] div_q;

    // Purpose: divider count, cleared on restart or when not running.
    always_ff @(posedge clk) begin
        if (!rst_n)                 div_q <= '0;
        else if (restart || !run)   div_q <= '0;
        else if (div_q == LAST)     div_q <= '0;
        else                        div_q <= div_q + 1'b1;
    end

    assign tick = run && !restart && (div_q == LAST);

    generate
        if (CLK_MHZ > 1) begin : g_tick_chk
            AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
                tick |=> !tick);  // R1
        end
    endgenerate

endmodule

// File: rtl/lbto_sel_decode.sv
// Module: lbto_sel_decode
// Registers the select code, which resets to code 0, and turns it into a limit in
// microseconds plus an off flag.
// Assumes the select input is static or changes only between transfers.
module lbto_sel_decode
    import lbto_pkg::*;
#(
    parameter int unsigned T0_US = 8,
    parameter int unsigned T1_US = 64,
    parameter int unsigned T2_US = 256,
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       sel_in,
    output logic [CNT_W-1:0] limit,
    output logic             off
);
    tmo_sel_e sel_q;

    // Purpose: hold the select code in effect, code 0 after reset.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= SEL_SHORT;
        else        sel_q <= tmo_sel_e'(sel_in);
    end

    // Purpose: map the code to a limit and an off flag.
    always_comb begin
        off   = 1'b0;
        limit = CNT_W'(T0_US);
        unique case (sel_q)
            SEL_SHORT: limit = CNT_W'(T0_US);
            SEL_MID:   limit = CNT_W'(T1_US);
            SEL_LONG:  limit = CNT_W'(T2_US);
            SEL_OFF:   off   = 1'b1;
            default:   off   = 1'b1;
        endcase
    end

    AST_SEL_RESET_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sel_q == SEL_SHORT));  // R12

endmodule

// File: rtl/lbto_cycle_ctrl.sv
// Module: lbto_cycle_ctrl
// Tracks one open bus cycle and counts microsecond ticks. It sends a one-clock error
// when the count reaches the limit. A start strobe restarts the count. A response
// closes the cycle and beats an expiry on the same edge.
// Assumes limit >= 1 while armed.
module lbto_cycle_ctrl #(
    parameter int unsigned CNT_W = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             ack,
    input  logic             err_ack,
    input  logic             armed,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             active,
    output logic             restart,
    output logic             err
);
    logic [CNT_W-1:0] us_cnt;
    logic             expire;

    assign restart = start && armed;
    assign expire  = (({1'b0, us_cnt} + 1'b1) == {1'b0, limit});

    // Purpose: cycle state, microsecond count and the error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            us_cnt <= '0;
            err    <= 1'b0;
        end else begin
            err <= 1'b0;
            if (!armed) begin
                active <= 1'b0;
                us_cnt <= '0;
            end else if (start) begin
                active <= 1'b1;
                us_cnt <= '0;
            end else if (ack || err_ack) begin
                active <= 1'b0;
                us_cnt <= '0;
            end else if (active && tick) begin
                if (expire) begin
                    err    <= 1'b1;
                    active <= 1'b0;
                    us_cnt <= '0;
                end else begin
                    us_cnt <= us_cnt + 1'b1;
                end
            end
        end
    end

    AST_ERR_NEEDS_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> $past(active));  // R1
    AST_ACK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !err);  // R7
    AST_EACK_NO_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        err_ack |=> !err);  // R8
    AST_START_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (active && us_cnt == '0));  // R9
    AST_ERR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> !err);  // R10
    AST_ERR_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !active);  // R10

endmodule

// File: rtl/lbus_tmo_monitor.sv
// Module: lbus_tmo_monitor (top)
// Local bus access timeout monitor. It times each transfer from its start strobe
// and sends a one-clock transfer error if no slave response comes within the
// selected limit.
// Assumes synchronous, single-clock handshake inputs.
module lbus_tmo_monitor
    import lbto_pkg::*;
#(
    parameter int unsigned CLK_MHZ = 125,
    parameter int unsigned T0_US   = 8,
    parameter int unsigned T1_US   = 64,
    parameter int unsigned T2_US   = 256
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xfer_start,
    input  logic       xfer_ack,
    input  logic       xfer_err_ack,
    input  logic [1:0] tmo_sel,
    input  logic       mon_enable,
    output logic       bus_err
);
    localparam int unsigned MAX_US = max3(T0_US, T1_US, T2_US);
    localparam int unsigned CNT_W  = $clog2(MAX_US + 1);

    logic [CNT_W-1:0] limit;
    logic             off, armed, tick, active, restart;

    assign armed = mon_enable && !off;

    lbto_sel_decode #(
        .T0_US(T0_US), .T1_US(T1_US), .T2_US(T2_US), .CNT_W(CNT_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .sel_in(tmo_sel), .limit(limit), .off(off)
    );

    lbto_tick_gen #(.CLK_MHZ(CLK_MHZ)) u_tick (
        .clk(clk), .rst_n(rst_n), .restart(restart), .run(active), .tick(tick)
    );

    lbto_cycle_ctrl #(.CNT_W(CNT_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .start(xfer_start), .ack(xfer_ack),
        .err_ack(xfer_err_ack), .armed(armed), .tick(tick), .limit(limit),
        .active(active), .restart(restart), .err(bus_err)
    );

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        off |=> !bus_err);  // R5
    AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !mon_enable |=> !bus_err);  // R6

endmodule

// File: tb/lbus_tmo_monitor_test.sv
module lbus_tmo_monitor_test;
    localparam int MHZ = 125;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       xfer_start = 1'b0, xfer_ack = 1'b0, xfer_err_ack = 1'b0;
    logic [1:0] tmo_sel = 2'd0;
    logic       mon_enable = 1'b1;
    logic       bus_err;
    int         checks = 0, errors = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    lbus_tmo_monitor #(.CLK_MHZ(MHZ)) uut (
        .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_ack(xfer_ack),
        .xfer_err_ack(xfer_err_ack), .tmo_sel(tmo_sel), .mon_enable(mon_enable),
        .bus_err(bus_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); xfer_start = 1'b1;
        @(negedge clk); xfer_start = 1'b0;
    endtask

    task automatic count_errs(input int n, output int errs);
        errs = 0;
        repeat (n) begin
            @(negedge clk);
            if (bus_err) errs++;
        end
    endtask

    // Clocks from the start edge until bus_err is seen, or -1 if it never is.
    task automatic measure(input int maxk, output int k);
        k = -1;
        for (int i = 1; i <= maxk; i++) begin
            @(negedge clk);
            if (bus_err) begin k = i; break; end
        end
    endtask

    task automatic set_sel(input logic [1:0] s);
        @(negedge clk); tmo_sel = s;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        int e;
        check(bus_err == 1'b0, "R12 reset output", bus_err, 0);
        count_errs(2000, e);
        check(e == 0, "R12 idle after reset", e, 0);
    endtask

    task automatic t_limit(input logic [1:0] s, input int us, input string req);
        int k, e;
        set_sel(s);
        pulse_start();
        measure(us * MHZ + 50, k);
        check(k == us * MHZ, {req, " R1 expiry clock"}, k, us * MHZ);
        @(negedge clk);
        check(bus_err == 1'b0, "R10 one clock pulse", bus_err, 0);
        count_errs(2000, e);
        check(e == 0, "R10 idle after error", e, 0);
    endtask

    task automatic t_off();
        int e;
        set_sel(2'd3);
        pulse_start();
        count_errs(300 * MHZ, e);
        check(e == 0, "R5 code 3 disables", e, 0);
    endtask

    task automatic t_enable_low();
        int e;
        set_sel(2'd0);
        mon_enable = 1'b0;
        pulse_start();
        count_errs(20 * MHZ, e);
        check(e == 0, "R6 enable low", e, 0);
        mon_enable = 1'b1;
    endtask

    task automatic t_response(input bit use_eack, input string req);
        int e;
        set_sel(2'd0);
        pulse_start();
        repeat (3 * MHZ) @(negedge clk);
        if (use_eack) xfer_err_ack = 1'b1; else xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0; xfer_err_ack = 1'b0;
        count_errs(20 * MHZ, e);
        check(e == 0, req, e, 0);
    endtask

    task automatic t_restart();
        int k;
        set_sel(2'd0);
        pulse_start();
        repeat (5 * MHZ - 1) @(negedge clk);
        pulse_start();
        measure(8 * MHZ + 50, k);
        check(k == 8 * MHZ, "R9 restart count", k, 8 * MHZ);
    endtask

    task automatic t_ack_at_expiry();
        int e;
        set_sel(2'd0);
        pulse_start();
        repeat (8 * MHZ - 1) @(negedge clk);
        xfer_ack = 1'b1;
        @(negedge clk);
        xfer_ack = 1'b0;
        check(bus_err == 1'b0, "R11 ack on expiry edge", bus_err, 0);
        count_errs(20 * MHZ, e);
        check(e == 0, "R11 quiet after tie", e, 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_limit(2'd0, 8, "R2");
        t_limit(2'd1, 64, "R3");
        t_limit(2'd2, 256, "R4");
        t_off();
        t_enable_low();
        t_response(1'b0, "R7 ack closes cycle");
        t_response(1'b1, "R8 error ack closes cycle");
        t_restart();
        t_ack_at_expiry();
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule